// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single management transactions against a PHY over the two-wire MDIO interface. A host pulses a start strobe together with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then shifts out a complete management frame, bit-banging MDC and MDIO itself. At the end it raises a one-cycle done pulse. For a read, the 16 bits returned by the PHY are presented on rdata.

Every bit the master drives takes three equal MDC phases: low, then high, then low again. MDIO does not change during those three phases. The `PHASE_CYCLES` parameter sets the length of one phase in system clocks. The MDIO line is shared, so the block also produces an output enable for the pad's tri-state buffer, and it receives the pad's input value.

Top module: `mdio_frame_master`

## Requirements
- R1: Out of reset and whenever no frame is in progress, mdc_o is low, mdio_oe_o is low, busy_o is low and done_o is low.
- R2: A frame drives, MSB first, 32 one bits, then the start pattern 0 then 1, then the opcode (1,0 for a read and 0,1 for a write), then the 5-bit PHY address, then the 5-bit register address. Each bit is the value of mdio_o at an MDC rising edge while mdio_oe_o is high.
- R3: Each MDC phase lasts PHASE_CYCLES clocks. A driven bit takes one low phase, one high phase and one low phase, and mdio_o and mdio_oe_o do not change while MDC is high.
- R4: In a write, the register address is followed by the driven turnaround pattern 1 then 0 and then by the 16 write-data bits, MSB first. This makes 64 driven bits in total.
- R5: After the last write-data bit, mdio_oe_o drops and MDC stays low for exactly one further phase with no extra pulse. A write therefore occupies 193 phases.
- R6: In a read, mdio_oe_o drops after the register address. One full undriven MDC pulse (low, high, low) follows as turnaround.
- R7: In a read, 16 data bits follow the turnaround, each as one high phase and one low phase. mdio_i is sampled in the last clock of each high phase and the bits are assembled MSB first. A read occupies 173 phases and ends on a low phase.
- R8: busy_o rises in the cycle after an accepted start strobe and falls in the cycle in which done_o pulses. A start strobe while busy_o is high has no effect on the frame in progress and starts no further frame.
- R9: done_o is high for exactly one cycle per frame. For a read, rdata_o holds the captured data from that cycle until a later read shifts in new data. Writes and idle time leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a frame |
| op_read_i | input | 1 | 1 = read transaction, 0 = write transaction |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Data for a write |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rdata_o | output | 16 | Data captured by the last read |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data toward the pad |
| mdio_oe_o | output | 1 | Drive enable for the data pad |
| mdio_i | input | 1 | Management data from the pad |

## Verification
The start strobe is accepted on a clock edge, and busy_o is high in the following cycle. It stays high for exactly 193×PHASE_CYCLES cycles for a write and 173×PHASE_CYCLES for a read. done_o appears in the next cycle, which is 193×PHASE_CYCLES+1 or 173×PHASE_CYCLES+1 cycles after acceptance. The bench samples every output on the falling clock edge. It counts busy cycles, MDC-high cycles and rising edges from one done pulse to the next. When done is seen, it compares those totals, the driven bit stream, the trailing low-phase length and rdata with the queued expectation. It checks the one-cycle width of done at the falling edge that follows.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_W      = 64;
    localparam int READ_HDR_W   = 46;
    localparam int RD_DATA_W    = 16;
    localparam int BITN_W       = $clog2(FRAME_W + 1);

    localparam logic [1:0] START_PAT = 2'b01;
    localparam logic [1:0] OP_RD     = 2'b10;
    localparam logic [1:0] OP_WR     = 2'b01;
    localparam logic [1:0] TA_WR     = 2'b10;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_SEND,
        SEQ_TURN,
        SEQ_RECV,
        SEQ_RELEASE
    } seq_state_e;

    typedef struct packed {
        seq_state_e            state;
        logic [1:0]            phase;
        logic [BITN_W-1:0]     bitn;
        logic [FRAME_W-1:0]    shift;
        logic [RD_DATA_W-1:0]  rxd;
        logic                  rd;
        logic                  done;
    } seq_regs_t;

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
    parameter int PHASE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CYCLES - 1);

    generate
        if (PHASE_CYCLES == 1) begin : g_every
            assign tick_o = run_i;
        end else begin : g_count
            logic [CNT_W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (!run_i)
                    cnt_d = '0;
                else if (cnt_q == CNT_LAST)
                    cnt_d = '0;
                else
                    cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick_o = run_i && (cnt_q == CNT_LAST);
        end
    endgenerate
endmodule

// File: rtl/mdio_frame_pack.sv
module mdio_frame_pack
    import mdio_pkg::*;
(
    input  logic               op_read_i,
    input  logic [4:0]         phy_addr_i,
    input  logic [4:0]         reg_addr_i,
    input  logic [15:0]        wdata_i,
    output logic [FRAME_W-1:0] frame_o
);
    always_comb begin
        if (op_read_i)
            frame_o = {32'hFFFF_FFFF, START_PAT, OP_RD, phy_addr_i, reg_addr_i, 18'h0};
        else
            frame_o = {32'hFFFF_FFFF, START_PAT, OP_WR, phy_addr_i, reg_addr_i, TA_WR, wdata_i};
    end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 op_read_i,
    input  logic [FRAME_W-1:0]   frame_i,
    input  logic                 tick_i,
    input  logic                 mdio_i,
    output logic                 run_o,
    output logic                 done_o,
    output logic [RD_DATA_W-1:0] rdata_o,
    output logic                 mdc_o,
    output logic                 mdio_o,
    output logic                 mdio_oe_o
);
    localparam logic [BITN_W-1:0] LAST_WR = BITN_W'(FRAME_W - 1);
    localparam logic [BITN_W-1:0] LAST_RD = BITN_W'(READ_HDR_W - 1);
    localparam logic [BITN_W-1:0] LAST_RX = BITN_W'(RD_DATA_W - 1);

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            SEQ_IDLE: begin
                if (start_i) begin
                    r_d.state = SEQ_SEND;
                    r_d.phase = 2'd0;
                    r_d.bitn  = '0;
                    r_d.shift = frame_i;
                    r_d.rd    = op_read_i;
                end
            end
            SEQ_SEND: begin
                if (tick_i) begin
                    if (r_q.phase != 2'd2) begin
                        r_d.phase = r_q.phase + 2'd1;
                    end else begin
                        r_d.phase = 2'd0;
                        r_d.shift = {r_q.shift[FRAME_W-2:0], 1'b0};
                        if (r_q.bitn == (r_q.rd ? LAST_RD : LAST_WR)) begin
                            r_d.bitn  = '0;
                            r_d.state = r_q.rd ? SEQ_TURN : SEQ_RELEASE;
                        end else begin
                            r_d.bitn = r_q.bitn + 1'b1;
                        end
                    end
                end
            end
            SEQ_TURN: begin
                if (tick_i) begin
                    if (r_q.phase != 2'd2) begin
                        r_d.phase = r_q.phase + 2'd1;
                    end else begin
                        r_d.phase = 2'd0;
                        r_d.state = SEQ_RECV;
                    end
                end
            end
            SEQ_RECV: begin
                if (tick_i) begin
                    if (r_q.phase == 2'd0) begin
                        r_d.rxd   = {r_q.rxd[RD_DATA_W-2:0], mdio_i};
                        r_d.phase = 2'd1;
                    end else begin
                        r_d.phase = 2'd0;
                        if (r_q.bitn == LAST_RX) begin
                            r_d.state = SEQ_IDLE;
                            r_d.done  = 1'b1;
                        end else begin
                            r_d.bitn = r_q.bitn + 1'b1;
                        end
                    end
                end
            end
            SEQ_RELEASE: begin
                if (tick_i) begin
                    r_d.state = SEQ_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= SEQ_IDLE;
            r_q.phase <= '0;
            r_q.bitn  <= '0;
            r_q.shift <= '0;
            r_q.rxd   <= '0;
            r_q.rd    <= 1'b0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign run_o     = (r_q.state != SEQ_IDLE);
    assign done_o    = r_q.done;
    assign rdata_o   = r_q.rxd;
    assign mdio_oe_o = (r_q.state == SEQ_SEND);
    assign mdio_o    = (r_q.state == SEQ_SEND) && r_q.shift[FRAME_W-1];
    assign mdc_o     = (((r_q.state == SEQ_SEND) || (r_q.state == SEQ_TURN)) && (r_q.phase == 2'd1))
                     || ((r_q.state == SEQ_RECV) && (r_q.phase == 2'd0));
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
    parameter int PHASE_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        op_read_i,
    input  logic [4:0]  phy_addr_i,
    input  logic [4:0]  reg_addr_i,
    input  logic [15:0] wdata_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] rdata_o,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe_o,
    input  logic        mdio_i
);
    logic [mdio_pkg::FRAME_W-1:0] frame;
    logic                         run;
    logic                         tick;

    mdio_frame_pack u_pack (
        .op_read_i  (op_read_i),
        .phy_addr_i (phy_addr_i),
        .reg_addr_i (reg_addr_i),
        .wdata_i    (wdata_i),
        .frame_o    (frame)
    );

    mdio_phase_timer #(
        .PHASE_CYCLES (PHASE_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_read_i (op_read_i),
        .frame_i   (frame),
        .tick_i    (tick),
        .mdio_i    (mdio_i),
        .run_o     (run),
        .done_o    (done_o),
        .rdata_o   (rdata_o),
        .mdc_o     (mdc_o),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe_o)
    );

    assign busy_o = run;
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic [15:0] rdata_o,
    input logic        mdc_o,
    input logic        mdio_o,
    input logic        mdio_oe_o
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mdc_o && !mdio_oe_o));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R8
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R3
    data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdc_o |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(rdata_o));

    // R5
    release_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe_o) |-> !mdc_o);
endmodule

bind mdio_frame_master mdio_frame_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .rdata_o   (rdata_o),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_frame_master_tb.sv
module mdio_frame_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 4;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_read_i = 1'b0;
    logic [4:0]  phy_addr_i = '0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic        busy_o, done_o, mdc_o, mdio_o, mdio_oe_o;
    logic [15:0] rdata_o;
    logic        mdio_i = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_frame_master #(.PHASE_CYCLES(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_read_i(op_read_i),
        .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .mdc_o(mdc_o),
        .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
    );

    typedef struct {
        bit          is_read;
        logic [63:0] bits;
        logic [15:0] rdata;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   cur_read = 1'b0;
    logic [15:0] phy_resp = '0;
    logic [15:0] last_rdata = '0;
    bit   finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: rebuilds the frame from the pins and compares on done
    logic        prev_mdc = 1'b0;
    int          rise_cnt = 0, drv_cnt = 0, und_cnt = 0;
    int          high_cyc = 0, busy_cyc = 0, tail = 0;
    logic [63:0] bits = '0;
    bit          check_done_low = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (check_done_low) begin
                chk(!done_o, "R9 done width", 64'(done_o), 64'd0);
                check_done_low = 1'b0;
            end
            if (mdc_o && !prev_mdc) begin
                rise_cnt++;
                if (mdio_oe_o) begin
                    bits = {bits[62:0], mdio_o};
                    drv_cnt++;
                end else begin
                    und_cnt++;
                end
            end
            if (!mdc_o && prev_mdc && cur_read && rise_cnt >= 47 && rise_cnt - 47 < 16)
                mdio_i = phy_resp[15 - (rise_cnt - 47)];
            if (mdc_o) high_cyc++;
            if (busy_o) busy_cyc++;
            if (mdc_o || mdio_oe_o) tail = 0;
            else if (busy_o) tail++;
            prev_mdc = mdc_o;

            if (done_o) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R8 unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (e.is_read) begin
                        chk(drv_cnt == 46, "R2 read driven bits", 64'(drv_cnt), 64'd46);
                        chk(bits[45:0] == e.bits[45:0], "R2 read header", bits, e.bits);
                        chk(und_cnt == 17, "R6 undriven pulses", 64'(und_cnt), 64'd17);
                        chk(high_cyc == 63*P, "R3 mdc high cycles", 64'(high_cyc), 64'(63*P));
                        chk(busy_cyc == 173*P, "R7 read length", 64'(busy_cyc), 64'(173*P));
                        chk(tail == P, "R7 final low phase", 64'(tail), 64'(P));
                        chk(rdata_o == e.rdata, "R7 read data", 64'(rdata_o), 64'(e.rdata));
                    end else begin
                        chk(drv_cnt == 64, "R4 write driven bits", 64'(drv_cnt), 64'd64);
                        chk(bits == e.bits, "R2 R4 write frame", bits, e.bits);
                        chk(und_cnt == 0, "R5 no extra pulse", 64'(und_cnt), 64'd0);
                        chk(high_cyc == 64*P, "R3 mdc high cycles", 64'(high_cyc), 64'(64*P));
                        chk(busy_cyc == 193*P, "R5 write length", 64'(busy_cyc), 64'(193*P));
                        chk(tail == P, "R5 release phase", 64'(tail), 64'(P));
                    end
                end
                check_done_low = 1'b1;
                rise_cnt = 0; drv_cnt = 0; und_cnt = 0;
                high_cyc = 0; busy_cyc = 0; tail = 0; bits = '0;
                mdio_i = 1'b1;
            end
        end
    end

    // Driver: queues the expectation and launches one frame
    task automatic run_frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic [15:0] resp, input bit poke);
        exp_t e;
        e.is_read = rd;
        e.rdata   = resp;
        if (rd) e.bits = {18'h0, 32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra};
        else    e.bits = {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, wd};
        sb.push_back(e);
        cur_read = rd;
        phy_resp = resp;
        @(negedge clk);
        op_read_i = rd; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R8 busy after start", 64'(busy_o), 64'd1);
        if (poke) begin
            repeat (100) @(negedge clk);
            op_read_i = ~rd; phy_addr_i = ~pa; reg_addr_i = ~ra; wdata_i = ~wd; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        chk(!busy_o, "R8 busy low at done", 64'(busy_o), 64'd0);
        repeat (5) begin
            @(negedge clk);
            chk(!busy_o && !mdc_o && !mdio_oe_o, "R1 R8 idle after frame",
                64'({busy_o, mdc_o, mdio_oe_o}), 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!mdc_o && !mdio_oe_o && !busy_o && !done_o, "R1 reset state",
            64'({mdc_o, mdio_oe_o, busy_o, done_o}), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!mdc_o && !mdio_oe_o && !busy_o, "R1 idle after reset",
            64'({mdc_o, mdio_oe_o, busy_o}), 64'd0);

        run_frame(1'b0, 5'h01, 5'h00, 16'h8000, 16'h0000, 1'b0);
        run_frame(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000, 1'b0);
        run_frame(1'b0, 5'h0A, 5'h15, 16'hA55A, 16'h0000, 1'b0);
        run_frame(1'b1, 5'h03, 5'h01, 16'h0000, 16'h782D, 1'b0);
        run_frame(1'b1, 5'h1F, 5'h10, 16'h0000, 16'hFFFF, 1'b0);
        run_frame(1'b1, 5'h00, 5'h02, 16'h0000, 16'h8001, 1'b0);
        last_rdata = 16'h8001;
        repeat (20) @(negedge clk);
        chk(rdata_o == last_rdata, "R9 rdata held idle", 64'(rdata_o), 64'(last_rdata));
        // start during busy is ignored (R8)
        run_frame(1'b0, 5'h12, 5'h07, 16'h3C3C, 16'h0000, 1'b1);
        chk(rdata_o == last_rdata, "R9 rdata held over write", 64'(rdata_o), 64'(last_rdata));
        run_frame(1'b1, 5'h05, 5'h1E, 16'h0000, 16'h1234, 1'b1);
        chk(sb.size() == 0, "R8 all frames completed", 64'(sb.size()), 64'd0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule